// File: doc/BRIEF.md
# Double-Precision Floating-Point Multiplier

This block multiplies two 64-bit binary floating-point operands in the common double format and returns a 64-bit product with overflow and underflow flags. Each operand is split into a sign, an 11-bit biased exponent and a 52-bit fraction. A leading one is put back in front of the fraction to form a 53-bit significand. The two significands are multiplied unsigned into a 106-bit product. That multiplier is built from a grid of small square cells. Each cell forms its partial products column by column (vertical and crosswise), and the grid adds the cell outputs along the same diagonal columns one level up. The product is then normalized by at most one place and truncated toward zero. The exponent is adjusted and the result is repacked.

A zero operand skips the arithmetic: the result is a zero carrying the XOR of the two signs. Results outside the normal exponent range become a signed infinity or a signed zero and raise a flag. Operands are presented with a valid strobe. The result, the flags and a matching valid appear from a register one clock later.

Top module: `fp64_vmul`

## Requirements
- R1: An operand whose exponent field (bits 62:52) is 0 counts as zero, whatever its fraction. If either operand is zero, the product has exponent and fraction 0 and both flags are 0.
- R2: Bit 63 of the product always equals the XOR of bit 63 of the two operands. This includes zero, infinite and flushed results.
- R3: The significands {1, fraction} are multiplied exactly as 53x53 unsigned values. If bit 105 of that 106-bit product is 1, the result fraction is bits 104:53; otherwise it is bits 103:52. The fraction is truncated, with no rounding increment.
- R4: The result exponent field is ea + eb − 1023, plus 1 when bit 105 of the significand product is 1. It is computed signed in a 16-bit adder.
- R5: If the adjusted exponent is above 2046, out_ovf is 1 and the product is a signed infinity (exponent 0x7FF, fraction 0). An adjusted exponent of exactly 2046 is a normal result with out_ovf 0.
- R6: If the adjusted exponent is below 1, out_unf is 1 and the product is a signed zero. An adjusted exponent of exactly 1 is a normal result with out_unf 0.
- R7: When in_valid is 1 at a rising clock edge, out_prod, out_ovf and out_unf take that operation's result at that edge, and out_valid is 1 until the next edge. When in_valid is 0 at an edge, out_valid is 0 after it.
- R8: While in_valid is 0, out_prod, out_ovf and out_unf keep their values, whatever happens on in_a and in_b.
- R9: While rst_n is 0, out_valid, out_prod, out_ovf and out_unf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Registered result valid |
| out_prod | output | 64 | Registered product |
| out_ovf | output | 1 | Result exponent exceeded the finite range |
| out_unf | output | 1 | Result exponent fell below the normal range |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction, 8-bit cells and zero gating enabled. With 53-bit significands and 8-bit cells, the grid is 7 by 7 and the top digit is only partly filled. Random operands therefore drive carries across every diagonal column, including the padded one. Random exponents span the whole field, so overflow, underflow, flushed zeros and the normalization carry all occur often. Directed vectors pin the exact 2046 and 1 exponent boundaries and the truncation of the lowest fraction bits.

// File: rtl/fp64vm_pkg.sv
package fp64vm_pkg;
   typedef enum logic [1:0] {
      RC_NORMAL = 2'd0,
      RC_ZERO   = 2'd1,
      RC_OVF    = 2'd2,
      RC_UNF    = 2'd3
   } res_class_e;
endpackage

// File: rtl/vm_cell.sv
module vm_cell #(
   parameter int W = 8
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);
   localparam int PW = 2 * W;
   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] col;
   logic [PW-1:0] acc;

   // Column k gathers every bit pair a[i]&b[j] with i+j == k.
   always_comb begin
      acc = '0;
      for (int k = 0; k < PW - 1; k++) begin
         col = '0;
         for (int i = 0; i < W; i++) begin
            for (int j = 0; j < W; j++) begin
               if (i + j == k) col = col + CW'(a[i] & b[j]);
            end
         end
         acc = acc + (PW'(col) << k);
      end
   end

   assign p = acc;
endmodule

// File: rtl/vm_sig_mult.sv
module vm_sig_mult #(
   parameter int SIG_W  = 53,
   parameter int CELL_W = 8
) (
   input  logic [SIG_W-1:0]   a,
   input  logic [SIG_W-1:0]   b,
   output logic [2*SIG_W-1:0] p
);
   localparam int ND   = (SIG_W + CELL_W - 1) / CELL_W;
   localparam int PADW = ND * CELL_W;
   localparam int CPW  = 2 * CELL_W;
   localparam int SW   = CPW + $clog2(ND + 1);
   localparam int AW   = 2 * PADW;

   if (CELL_W < 2 || CELL_W > SIG_W) begin : g_bad_cell
      $error("vm_sig_mult: CELL_W must lie in 2..SIG_W");
   end

   logic [PADW-1:0] a_pad, b_pad;
   assign a_pad = PADW'(a);
   assign b_pad = PADW'(b);

   logic [CPW-1:0] pp [ND][ND];

   for (genvar gi = 0; gi < ND; gi++) begin : g_row
      for (genvar gj = 0; gj < ND; gj++) begin : g_col
         vm_cell #(.W(CELL_W)) u_cell (
            .a (a_pad[gi*CELL_W +: CELL_W]),
            .b (b_pad[gj*CELL_W +: CELL_W]),
            .p (pp[gi][gj])
         );
      end
   end

   logic [SW-1:0] dsum;
   logic [AW-1:0] acc;

   // Second level: digit products summed along the same crosswise diagonals.
   always_comb begin
      acc = '0;
      for (int k = 0; k < 2 * ND - 1; k++) begin
         dsum = '0;
         for (int i = 0; i < ND; i++) begin
            for (int j = 0; j < ND; j++) begin
               if (i + j == k) dsum = dsum + SW'(pp[i][j]);
            end
         end
         acc = acc + (AW'(dsum) << (k * CELL_W));
      end
   end

   assign p = acc[2*SIG_W-1:0];
endmodule

// File: rtl/vm_norm_pack.sv
module vm_norm_pack
   import fp64vm_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int FRAC_W = 52,
   parameter int ACC_W = 16
) (
   input  logic                      sign,
   input  logic                      is_zero,
   input  logic [EXP_W-1:0]          ea,
   input  logic [EXP_W-1:0]          eb,
   input  logic [2*FRAC_W+1:0]       prod,
   output logic [EXP_W+FRAC_W:0]     result,
   output res_class_e                rclass
);
   localparam int PW   = 2 * (FRAC_W + 1);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int MAXE = (1 << EXP_W) - 2;

   if (ACC_W < EXP_W + 3) begin : g_bad_acc
      $error("vm_norm_pack: ACC_W too narrow for the exponent sum");
   end

   logic                     carry;
   logic [FRAC_W-1:0]        frac;
   logic [ACC_W-1:0]         e_u;
   logic signed [ACC_W-1:0]  e_s;

   assign carry = prod[PW-1];
   assign frac  = carry ? prod[PW-2 -: FRAC_W] : prod[PW-3 -: FRAC_W];
   assign e_u   = ACC_W'(ea) + ACC_W'(eb) + ACC_W'(carry) - ACC_W'(BIAS);
   assign e_s   = $signed(e_u);

   always_comb begin
      if (is_zero)                                rclass = RC_ZERO;
      else if (e_s > $signed(ACC_W'(MAXE)))       rclass = RC_OVF;
      else if (e_s < $signed(ACC_W'(1)))          rclass = RC_UNF;
      else                                        rclass = RC_NORMAL;
   end

   always_comb begin
      unique case (rclass)
         RC_NORMAL: result = {sign, e_u[EXP_W-1:0], frac};
         RC_OVF:    result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         default:   result = {sign, {(EXP_W+FRAC_W){1'b0}}};
      endcase
   end
endmodule

// File: rtl/fp64_vmul.sv
module fp64_vmul
   import fp64vm_pkg::*;
#(
   parameter int EXP_W     = 11,
   parameter int FRAC_W    = 52,
   parameter int CELL_W    = 8,
   parameter int ACC_W     = 16,
   parameter bit ZERO_GATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [EXP_W+FRAC_W:0]      in_a,
   input  logic [EXP_W+FRAC_W:0]      in_b,
   output logic                       out_valid,
   output logic [EXP_W+FRAC_W:0]      out_prod,
   output logic                       out_ovf,
   output logic                       out_unf
);
   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int SIG_W = FRAC_W + 1;
   localparam int PW    = 2 * SIG_W;
   localparam logic [PW-1:0] PROD_MIN = PW'(1) << (PW - 2);

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_fmt
      $error("fp64_vmul: exponent and fraction need at least 2 bits");
   end

   logic              sa, sb, r_sign, any_zero;
   logic [EXP_W-1:0]  ea, eb;
   logic [FRAC_W-1:0] fa, fb;

   assign {sa, ea, fa} = in_a;
   assign {sb, eb, fb} = in_b;
   assign r_sign   = sa ^ sb;
   assign any_zero = (ea == '0) || (eb == '0);

   logic [SIG_W-1:0] sig_a, sig_b;
   if (ZERO_GATE) begin : g_gate
      // Hold the multiplier quiet when a zero operand bypasses it.
      assign sig_a = any_zero ? '0 : {1'b1, fa};
      assign sig_b = any_zero ? '0 : {1'b1, fb};
   end else begin : g_nogate
      assign sig_a = {1'b1, fa};
      assign sig_b = {1'b1, fb};
   end

   logic [PW-1:0] sig_prod;
   vm_sig_mult #(.SIG_W(SIG_W), .CELL_W(CELL_W)) u_mult (
      .a (sig_a),
      .b (sig_b),
      .p (sig_prod)
   );

   logic [W-1:0] nxt_prod;
   res_class_e   nxt_class;
   vm_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_norm (
      .sign    (r_sign),
      .is_zero (any_zero),
      .ea      (ea),
      .eb      (eb),
      .prod    (sig_prod),
      .result  (nxt_prod),
      .rclass  (nxt_class)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_prod  <= '0;
         out_ovf   <= 1'b0;
         out_unf   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_prod <= nxt_prod;
            out_ovf  <= (nxt_class == RC_OVF);
            out_unf  <= (nxt_class == RC_UNF);
         end
      end
   end

   AST_SIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !any_zero) |-> (sig_prod >= PROD_MIN)); // R3
   AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_prod[W-1] == $past(in_a[W-1] ^ in_b[W-1]))); // R2
   AST_ZERO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_a[W-2 -: EXP_W] == '0)) |=>
         (out_prod[W-2:0] == '0 && !out_ovf && !out_unf)); // R1
   AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> (out_prod[W-2 -: EXP_W] == '1 && out_prod[FRAC_W-1:0] == '0)); // R5
   AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_unf |-> (out_prod[W-2:0] == '0 && !out_ovf)); // R6
   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R7
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R7
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_prod) && $stable(out_ovf) && $stable(out_unf))); // R8
endmodule

// File: tb/tb_fp64_vmul.sv
module tb_fp64_vmul;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_a = '0, in_b = '0;
   logic        out_valid, out_ovf, out_unf;
   logic [63:0] out_prod;

   int vecs = 0;
   int errs = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fp64_vmul dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_prod(out_prod), .out_ovf(out_ovf), .out_unf(out_unf)
   );

   // Expected {ovf, unf, product} from the requirements.
   function automatic logic [65:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
      logic        s;
      logic [105:0] p;
      logic [51:0] f;
      int          e;
      s = a[63] ^ b[63];
      if (a[62:52] == 0 || b[62:52] == 0) return {2'b00, s, 63'b0};
      p = {53'b0, 1'b1, a[51:0]} * {53'b0, 1'b1, b[51:0]};
      e = int'(a[62:52]) + int'(b[62:52]) - 1023;
      if (p[105]) begin e = e + 1; f = p[104:53]; end
      else f = p[103:52];
      if (e > 2046) return {2'b10, s, 11'h7FF, 52'b0};
      if (e < 1) return {2'b01, s, 63'b0};
      return {2'b00, s, e[10:0], f};
   endfunction

   task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
      vecs++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: got ovf/unf/prod %b/%b/%h, expected %b/%b/%h",
                  tag, got[65], got[64], got[63:0], exp[65], exp[64], exp[63:0]);
      end
   endtask

   task automatic run_vec(input string tag, input logic [63:0] a, input logic [63:0] b,
                          input logic [65:0] exp);
      @(negedge clk);
      in_valid = 1'b1; in_a = a; in_b = b;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R7 valid"}, {65'b0, out_valid}, 66'd1);
      check(tag, {out_ovf, out_unf, out_prod}, exp);
   endtask

   function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] f);
      return {s, e[10:0], f};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      logic [65:0] held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R9 reset", {out_ovf, out_unf, out_prod}, 66'd0);
      check("R9 reset valid", {65'b0, out_valid}, 66'd0);
      @(negedge clk); rst_n = 1'b1;

      run_vec("R3 1.5*2", $realtobits(1.5), $realtobits(2.0), {2'b00, $realtobits(3.0)});
      run_vec("R2 -2.5*4", $realtobits(-2.5), $realtobits(4.0), {2'b00, $realtobits(-10.0)});
      run_vec("R4 3*3 carry", $realtobits(3.0), $realtobits(3.0), {2'b00, $realtobits(9.0)});
      run_vec("R1 0*-5", 64'd0, $realtobits(-5.0), {2'b00, 64'h8000_0000_0000_0000});
      run_vec("R1 subnormal flushed", 64'h0000_0000_0000_0001, $realtobits(7.0), 66'd0);
      run_vec("R3 truncate low", 64'h3FF0_0000_0000_0001, 64'h3FF0_0000_0000_0001,
              {2'b00, 64'h3FF0_0000_0000_0002});
      run_vec("R3 truncate carry", 64'h3FFF_FFFF_FFFF_FFFF, 64'h3FFF_FFFF_FFFF_FFFF,
              {2'b00, 64'h400F_FFFF_FFFF_FFFE});
      run_vec("R5 edge 2046", mk(0, 1535, 0), mk(0, 1534, 0), {2'b00, mk(0, 2046, 0)});
      run_vec("R5 overflow", mk(1, 1536, 0), mk(0, 1534, 0), {2'b10, 64'hFFF0_0000_0000_0000});
      run_vec("R5 overflow by carry", mk(0, 1535, '1), mk(0, 1534, '1),
              {2'b10, 64'h7FF0_0000_0000_0000});
      run_vec("R6 edge 1", mk(0, 512, 0), mk(0, 512, 0), {2'b00, mk(0, 1, 0)});
      run_vec("R6 underflow", mk(0, 512, 0), mk(1, 511, 0), {2'b01, 64'h8000_0000_0000_0000});

      // R8: operands change without in_valid; outputs must hold.
      held = {out_ovf, out_unf, out_prod};
      in_a = $realtobits(123.0); in_b = $realtobits(-4.0);
      @(negedge clk);
      check("R8 hold", {out_ovf, out_unf, out_prod}, held);
      check("R7 idle valid", {65'b0, out_valid}, 66'd0);

      for (int n = 0; n < 3000; n++) begin
         logic [63:0] a, b;
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         if (a[62:52] == 11'h7FF) a[62] = 1'b0;
         if (b[62:52] == 11'h7FF) b[62] = 1'b0;
         if (n % 97 == 0) a[62:52] = '0;
         if (n % 5 == 0) begin a[62:52] = 11'd1023 + 11'($urandom_range(0, 60)); end
         run_vec("R3/R4/R5/R6 random", a, b, ref_mul(a, b));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule